// File: doc/BRIEF.md
# Hashed Page-Table Group Searcher

This block looks up one virtual page in a hashed page table held in memory. On a start pulse it takes a 32-bit match word, the byte addresses of a primary and a secondary entry group, the protection key, and whether the access is a write. It walks the primary group entry by entry through a word-read memory port. An entry is two 32-bit words: a tag word and a translation word. If no entry of the primary group matches, it walks the secondary group in the same way.

Every matching entry in a pass is compared against the first one. Their translation words must agree on the page number, the storage-attribute bits and the protection bits. If they agree, the block decides from the first match's protection bits and the key whether the access is allowed. It then reports the page number, the four storage-attribute bits and the two protection bits. When an allowed access sets a referenced or changed flag that was still clear, the block writes the translation word back to memory.

Top module: `pteg_search`

## Requirements
- R1: After a synchronous reset, `done` and `mem_req` are low and stay low until `start` is seen.
- R2: An entry matches only when tag bit 31 is 1, tag bit 6 equals the pass (0 for primary, 1 for secondary), and the tag ANDed with 0x7FFFFFBF equals `match_word`.
- R3: Within a pass, the block reads tag words at base+8*i for i = 0 to 7 in increasing order. It reads the translation word at base+8*i+4 only for an entry whose tag matches. Only one read is outstanding at a time, and every address is word aligned.
- R4: The secondary group is read only when the primary pass found no matching entry.
- R5: If a later matching entry's translation word ANDed with 0xFFFFF07B differs from the first match's, the result is 3 (inconsistent) and the search stops at once. No write-back follows. Matches that agree under this mask give a normal outcome.
- R6: The first match of the pass is the chosen entry. `rpn` is its translation word bits 31:12, `wimg` is bits 6:3, and `pp` is bits 1:0. The same fields are reported when the result is 2. All three are zero for results 1 and 3.
- R7: Access is allowed as follows. With key 0: pp 0, 1 and 2 allow read and write, and pp 3 allows read only. With key 1: pp 0 allows nothing, pp 1 and pp 3 allow read only, and pp 2 allows read and write. A hit that is not allowed gives result 2.
- R8: On an allowed hit, the new translation word is the old one with bit 8 set, and also bit 7 set for a write. It is written to the chosen entry's translation-word address, with `mem_we` high, only when it differs from the old word. The write is issued in the same cycle as `done`.
- R9: `done` is a one-cycle pulse per search. `result` is 0 for hit, 1 for not found, 2 for protection violation and 3 for inconsistency, and it holds until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a search; sampled when idle |
| match_word | input | 32 | Tag to compare (bits 31 and 6 zero) |
| pri_base | input | ADDR_W | Byte address of the primary group |
| sec_base | input | ADDR_W | Byte address of the secondary group |
| key | input | 1 | Protection key |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| mem_req | output | 1 | Memory request, one cycle per access |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid, one cycle |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Search complete pulse |
| result | output | 2 | Outcome code |
| rpn | output | 32-PAGE_SHIFT | Real page number |
| wimg | output | 4 | Storage-attribute bits |
| pp | output | 2 | Protection bits |

## Verification
The block acts on read data at the clock edge where `mem_rvalid` is seen, and it issues the next request at that same edge. The next read request therefore appears one cycle after each response. After the last tag or translation word of a pass, one extra cycle decides the outcome. So `done` (with any write-back) appears two cycles after the last response is presented, and one cycle after it when that response reveals an inconsistency. The bench predicts the full ordered list of memory accesses from its own model of the table. It compares every request against that list on the cycle it appears, checks that `done` lands exactly one or two cycles after the last response, and runs with memory latencies of one to three cycles.

// File: rtl/pteg_pkg.sv
package pteg_pkg;

  typedef enum logic [1:0] {
    RES_HIT      = 2'd0,
    RES_MISS     = 2'd1,
    RES_PROT     = 2'd2,
    RES_CONFLICT = 2'd3
  } pteg_result_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TAG,
    ST_XLAT,
    ST_EVAL
  } pteg_state_e;

  localparam int          VALID_BIT  = 31;
  localparam int          HSEL_BIT   = 6;
  localparam logic [31:0] TAG_MASK   = 32'h7FFF_FFBF;
  localparam int          REF_BIT    = 8;
  localparam int          CHG_BIT    = 7;
  localparam int          WIMG_LO    = 3;
  localparam logic [31:0] ATTR_LOW   = 32'h0000_007B;

endpackage

// File: rtl/pteg_entry_match.sv
module pteg_entry_match
  import pteg_pkg::*;
(
  input  logic [31:0] tag_word,
  input  logic [31:0] match_word,
  input  logic        pass_sel,
  output logic        hit
);

  logic valid_ok;
  logic hsel_ok;
  logic tag_ok;

  assign valid_ok = tag_word[VALID_BIT];
  assign hsel_ok  = (tag_word[HSEL_BIT] == pass_sel);
  assign tag_ok   = ((tag_word & TAG_MASK) == match_word);
  assign hit      = valid_ok && hsel_ok && tag_ok;

endmodule

// File: rtl/pteg_perm.sv
module pteg_perm (
  input  logic       key,
  input  logic [1:0] pp,
  input  logic       is_write,
  output logic       allow
);

  logic rd_ok;
  logic wr_ok;

  always_comb begin
    rd_ok = 1'b1;
    wr_ok = 1'b0;
    unique case (pp)
      2'd0: begin rd_ok = !key; wr_ok = !key; end
      2'd1: begin rd_ok = 1'b1; wr_ok = !key; end
      2'd2: begin rd_ok = 1'b1; wr_ok = 1'b1; end
      default: begin rd_ok = 1'b1; wr_ok = 1'b0; end
    endcase
  end

  assign allow = is_write ? wr_ok : rd_ok;

endmodule

// File: rtl/pteg_rc_update.sv
module pteg_rc_update
  import pteg_pkg::*;
(
  input  logic [31:0] word_in,
  input  logic        is_write,
  output logic [31:0] word_out,
  output logic        changed
);

  always_comb begin
    word_out          = word_in;
    word_out[REF_BIT] = 1'b1;
    if (is_write) word_out[CHG_BIT] = 1'b1;
  end

  assign changed = (word_out != word_in);

endmodule

// File: rtl/pteg_search.sv
module pteg_search
  import pteg_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ENTRIES    = 8,
  parameter int PAGE_SHIFT = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [31:0]             match_word,
  input  logic [ADDR_W-1:0]       pri_base,
  input  logic [ADDR_W-1:0]       sec_base,
  input  logic                    key,
  input  logic                    acc_write,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [31:0]             mem_wdata,
  input  logic                    mem_rvalid,
  input  logic [31:0]             mem_rdata,
  output logic                    done,
  output logic [1:0]              result,
  output logic [31-PAGE_SHIFT:0]  rpn,
  output logic [3:0]              wimg,
  output logic [1:0]              pp
);

  localparam int          IDX_W      = $clog2(ENTRIES);
  localparam int          ENTRY_SH   = 3;
  localparam logic [31:0] CMP_MASK   = (32'hFFFF_FFFF << PAGE_SHIFT) | ATTR_LOW;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);
  localparam logic [ADDR_W-1:0] XLAT_OFS = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] STRIDE   = ADDR_W'(1 << ENTRY_SH);

  pteg_state_e        state_q;
  logic               pass_q;
  logic [IDX_W-1:0]   idx_q;
  logic [ADDR_W-1:0]  base_q;
  logic [31:0]        mw_q;
  logic               key_q;
  logic               wr_q;
  logic               found_q;
  logic [31:0]        first_q;
  logic [ADDR_W-1:0]  first_addr_q;

  logic [ADDR_W-1:0]  entry_addr;
  logic               last_entry;
  logic               tag_hit;
  logic               conflict;
  logic               allow;
  logic [31:0]        rc_word;
  logic               rc_changed;

  assign entry_addr = base_q + ({{(ADDR_W-IDX_W){1'b0}}, idx_q} << ENTRY_SH);
  assign last_entry = (idx_q == LAST_IDX);
  assign conflict   = ((mem_rdata & CMP_MASK) != (first_q & CMP_MASK));

  pteg_entry_match u_match (
    .tag_word   (mem_rdata),
    .match_word (mw_q),
    .pass_sel   (pass_q),
    .hit        (tag_hit)
  );

  pteg_perm u_perm (
    .key      (key_q),
    .pp       (first_q[1:0]),
    .is_write (wr_q),
    .allow    (allow)
  );

  pteg_rc_update u_rc (
    .word_in  (first_q),
    .is_write (wr_q),
    .word_out (rc_word),
    .changed  (rc_changed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      pass_q       <= 1'b0;
      idx_q        <= '0;
      base_q       <= '0;
      mw_q         <= '0;
      key_q        <= 1'b0;
      wr_q         <= 1'b0;
      found_q      <= 1'b0;
      first_q      <= '0;
      first_addr_q <= '0;
      mem_req      <= 1'b0;
      mem_we       <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      done         <= 1'b0;
      result       <= RES_MISS;
      rpn          <= '0;
      wimg         <= '0;
      pp           <= '0;
    end else begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
      done    <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            mw_q     <= match_word;
            key_q    <= key;
            wr_q     <= acc_write;
            pass_q   <= 1'b0;
            idx_q    <= '0;
            base_q   <= pri_base;
            found_q  <= 1'b0;
            mem_req  <= 1'b1;
            mem_addr <= pri_base;
            state_q  <= ST_TAG;
          end
        end

        ST_TAG: begin
          if (mem_rvalid) begin
            if (tag_hit) begin
              mem_req  <= 1'b1;
              mem_addr <= entry_addr + XLAT_OFS;
              state_q  <= ST_XLAT;
            end else if (last_entry) begin
              state_q <= ST_EVAL;
            end else begin
              idx_q    <= idx_q + 1'b1;
              mem_req  <= 1'b1;
              mem_addr <= entry_addr + STRIDE;
            end
          end
        end

        ST_XLAT: begin
          if (mem_rvalid) begin
            if (found_q && conflict) begin
              done    <= 1'b1;
              result  <= RES_CONFLICT;
              rpn     <= '0;
              wimg    <= '0;
              pp      <= '0;
              state_q <= ST_IDLE;
            end else begin
              if (!found_q) begin
                found_q      <= 1'b1;
                first_q      <= mem_rdata;
                first_addr_q <= mem_addr;
              end
              if (last_entry) begin
                state_q <= ST_EVAL;
              end else begin
                idx_q    <= idx_q + 1'b1;
                mem_req  <= 1'b1;
                mem_addr <= entry_addr + STRIDE;
                state_q  <= ST_TAG;
              end
            end
          end
        end

        ST_EVAL: begin
          if (found_q) begin
            done    <= 1'b1;
            rpn     <= first_q[31:PAGE_SHIFT];
            wimg    <= first_q[WIMG_LO+3:WIMG_LO];
            pp      <= first_q[1:0];
            state_q <= ST_IDLE;
            if (!allow) begin
              result <= RES_PROT;
            end else begin
              result <= RES_HIT;
              if (rc_changed) begin
                mem_req   <= 1'b1;
                mem_we    <= 1'b1;
                mem_addr  <= first_addr_q;
                mem_wdata <= rc_word;
              end
            end
          end else if (!pass_q) begin
            pass_q   <= 1'b1;
            idx_q    <= '0;
            base_q   <= sec_base;
            mem_req  <= 1'b1;
            mem_addr <= sec_base;
            state_q  <= ST_TAG;
          end else begin
            done    <= 1'b1;
            result  <= RES_MISS;
            rpn     <= '0;
            wimg    <= '0;
            pp      <= '0;
            state_q <= ST_IDLE;
          end
        end

        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pteg_search_chk.sv
module pteg_search_chk (
  input logic       clk,
  input logic       rst,
  input logic       mem_req,
  input logic       mem_we,
  input logic [1:0] addr_lo,
  input logic       wdata_ref,
  input logic       mem_rvalid,
  input logic       done,
  input logic [1:0] result
);

  logic outst;

  always_ff @(posedge clk) begin
    if (rst)                      outst <= 1'b0;
    else if (mem_req && !mem_we)  outst <= 1'b1;
    else if (mem_rvalid)          outst <= 1'b0;
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (!done && !mem_req));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r3_one_outstanding: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> !outst);

  a_r3_word_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (addr_lo == 2'b00));

  a_r8_wb_on_hit_only: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (done && result == 2'd0));

  a_r8_wb_sets_ref: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> wdata_ref);

  a_r9_no_read_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !(mem_req && !mem_we));

endmodule

bind pteg_search pteg_search_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .addr_lo    (mem_addr[1:0]),
  .wdata_ref  (mem_wdata[8]),
  .mem_rvalid (mem_rvalid),
  .done       (done),
  .result     (result)
);

// File: tb/tb_pteg_search.sv
module tb_pteg_search;
  localparam int PERIOD = 10;
  localparam logic [31:0] PRI = 32'h0000_0000;
  localparam logic [31:0] SEC = 32'h0000_0040;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [31:0] match_word = '0;
  logic key = 1'b0, acc_write = 1'b0;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic done;
  logic [1:0] result;
  logic [19:0] rpn;
  logic [3:0] wimg;
  logic [1:0] pp;

  int errors = 0, checks = 0;
  logic [31:0] mem [0:63];
  logic [31:0] qa[$];
  bit          qwe[$];
  logic [31:0] qd[$];
  logic [1:0]  e_res;
  logic [19:0] e_rpn;
  logic [3:0]  e_wimg;
  logic [1:0]  e_pp;
  string cur_req = "R1";
  int lat = 1, cnt = 0, cyc = 0, last_rv = 0;
  bit pend = 0, got_done = 0;
  logic [31:0] paddr = '0;

  pteg_search dut (
    .clk(clk), .rst(rst), .start(start), .match_word(match_word),
    .pri_base(PRI), .sec_base(SEC), .key(key), .acc_write(acc_write),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .done(done), .result(result), .rpn(rpn), .wimg(wimg), .pp(pp)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit allowed(input bit k, input logic [1:0] p, input bit w);
    if (p == 2'd2) return 1'b1;
    if (!k && p != 2'd3) return 1'b1;
    if (w) return 1'b0;
    return !(k && p == 2'd0);
  endfunction

  task automatic predict(input logic [31:0] mw, input bit k, input bit w);
    bit stop = 0;
    qa.delete(); qwe.delete(); qd.delete();
    e_res = 2'd1; e_rpn = '0; e_wimg = '0; e_pp = '0;
    for (int pass = 0; pass < 2 && !stop; pass++) begin
      logic [31:0] base = (pass == 0) ? PRI : SEC;
      bit found = 0;
      logic [31:0] f1 = '0, fa = '0;
      for (int i = 0; i < 8 && !stop; i++) begin
        logic [31:0] a0 = base + 8*i;
        logic [31:0] t  = mem[a0[7:2]];
        qa.push_back(a0); qwe.push_back(0); qd.push_back('0);
        if (t[31] == 1'b1 && t[6] == pass[0] && (t & 32'h7FFF_FFBF) == mw) begin
          logic [31:0] x = mem[(a0 + 4) >> 2];
          qa.push_back(a0 + 4); qwe.push_back(0); qd.push_back('0);
          if (!found) begin found = 1; f1 = x; fa = a0 + 4; end
          else if ((x & 32'hFFFF_F07B) != (f1 & 32'hFFFF_F07B)) begin
            e_res = 2'd3; stop = 1;
          end
        end
      end
      if (found && !stop) begin
        stop = 1;
        e_rpn = f1[31:12]; e_wimg = f1[6:3]; e_pp = f1[1:0];
        if (!allowed(k, f1[1:0], w)) e_res = 2'd2;
        else begin
          logic [31:0] nw = f1 | 32'h100 | (w ? 32'h80 : 32'h0);
          e_res = 2'd0;
          if (nw != f1) begin qa.push_back(fa); qwe.push_back(1); qd.push_back(nw); end
        end
      end
    end
  endtask

  always @(negedge clk) begin
    logic [31:0] a, d;
    bit w;
    cyc++;
    mem_rvalid = 1'b0;
    if (pend) begin
      cnt--;
      if (cnt == 0) begin
        pend = 0; mem_rvalid = 1'b1; mem_rdata = mem[paddr[7:2]]; last_rv = cyc;
      end
    end
    if (!rst && mem_req) begin
      if (qa.size() == 0) begin
        chk(cur_req, mem_addr, 32'hFFFF_FFFF, "unexpected request address");
      end else begin
        a = qa.pop_front(); w = qwe.pop_front(); d = qd.pop_front();
        chk(cur_req, mem_addr, a, "request address (R3)");
        chk(cur_req, {31'b0, mem_we}, {31'b0, w}, "request kind (R8)");
        if (w) chk(cur_req, mem_wdata, d, "write-back data (R8)");
      end
      if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
      else begin
        if (pend) chk("R3", 32'd1, 32'd0, "second outstanding read");
        pend = 1; cnt = lat; paddr = mem_addr;
      end
    end
    if (!rst && done) begin
      got_done = 1;
      chk(cur_req, {30'b0, result}, {30'b0, e_res}, "result (R9)");
      chk(cur_req, {12'b0, rpn}, {12'b0, e_rpn}, "rpn (R6)");
      chk(cur_req, {28'b0, wimg}, {28'b0, e_wimg}, "wimg (R6)");
      chk(cur_req, {30'b0, pp}, {30'b0, e_pp}, "pp (R6)");
      chk(cur_req, qa.size(), 0, "accesses left at done (R3)");
      chk(cur_req, cyc - last_rv, (e_res == 2'd3) ? 1 : 2, "done latency (R9)");
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = '0;
  endtask

  task automatic put(input logic [31:0] base, input int i, input logic [31:0] t, input logic [31:0] x);
    mem[(base + 8*i) >> 2]     = t;
    mem[(base + 8*i + 4) >> 2] = x;
  endtask

  task automatic run(input string req, input logic [31:0] mw, input bit k, input bit w, input int l);
    predict(mw, k, w);
    cur_req = req; lat = l; got_done = 0;
    @(negedge clk);
    start = 1'b1; match_word = mw; key = k; acc_write = w;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 400 && !got_done; n++) @(negedge clk);
    #1;
    chk(req, {31'b0, got_done}, 32'd1, "search completed (R9)");
    repeat (3) @(negedge clk);
    chk(req, {31'b0, done}, 32'd0, "done is a single pulse (R9)");
  endtask

  localparam logic [31:0] MW  = 32'h1234_5A01;
  localparam logic [31:0] TP  = 32'h8000_0000 | MW;
  localparam logic [31:0] TS  = 32'h8000_0040 | MW;

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    chk("R1", {31'b0, done}, 32'd0, "done in reset");
    chk("R1", {31'b0, mem_req}, 32'd0, "mem_req in reset");
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", {31'b0, done | mem_req}, 32'd0, "quiet after reset");

    // R2: invalid and wrong-pass entries skipped, R8 referenced bit set
    put(PRI, 1, TP & 32'h7FFF_FFFF, 32'h9999_9002);
    put(PRI, 2, TS, 32'h8888_8002);
    put(PRI, 3, TP, 32'hABCD_E02A);
    run("R2", MW, 1'b0, 1'b0, 1);
    chk("R6", {12'b0, rpn}, 32'h000A_BCDE, "rpn of entry 3");
    chk("R8", mem[(PRI + 28) >> 2], 32'hABCD_E12A, "referenced bit written");

    run("R8", MW, 1'b0, 1'b0, 2);
    chk("R8", mem[(PRI + 28) >> 2], 32'hABCD_E12A, "no rewrite when unchanged");
    run("R8", MW, 1'b0, 1'b1, 3);
    chk("R8", mem[(PRI + 28) >> 2], 32'hABCD_E1AA, "changed bit written");

    // R4: secondary pass after primary miss
    clear_mem();
    put(PRI, 0, TS, 32'h7777_7002);
    put(SEC, 5, TS, 32'h1111_1019);
    run("R4", MW, 1'b0, 1'b0, 2);
    chk("R4", {30'b0, result}, 32'd0, "hit in secondary");
    chk("R4", {12'b0, rpn}, 32'h0001_1111, "secondary rpn");

    // R9: miss everywhere
    put(SEC, 5, TS ^ 32'h0000_0100, 32'h1111_1019);
    run("R9", MW, 1'b0, 1'b0, 1);
    chk("R9", {30'b0, result}, 32'd1, "not found");

    // R5: consistent multiple matches, first chosen
    clear_mem();
    put(PRI, 2, TP, 32'h2222_2010);
    put(PRI, 6, TP, 32'h2222_2194);
    run("R5", MW, 1'b0, 1'b0, 1);
    chk("R5", {30'b0, result}, 32'd0, "consistent matches hit");
    chk("R6", mem[(PRI + 20) >> 2], 32'h2222_2110, "first match updated");

    // R5: inconsistent matches stop the search
    clear_mem();
    put(PRI, 1, TP, 32'h3333_3012);
    put(PRI, 4, TP, 32'h3333_4012);
    put(PRI, 6, TP, 32'h3333_3012);
    run("R5", MW, 1'b0, 1'b0, 3);
    chk("R5", {30'b0, result}, 32'd3, "inconsistency reported");
    chk("R5", mem[(PRI + 12) >> 2], 32'h3333_3012, "no write-back on conflict");

    // R7: permission table
    clear_mem();
    put(PRI, 0, TP, 32'h4444_4000);
    run("R7", MW, 1'b1, 1'b0, 1);
    chk("R7", {30'b0, result}, 32'd2, "key1 pp0 read denied");
    chk("R7", mem[(PRI + 4) >> 2], 32'h4444_4000, "denied access leaves flags");
    put(PRI, 0, TP, 32'h4444_4003);
    run("R7", MW, 1'b0, 1'b1, 2);
    chk("R7", {30'b0, result}, 32'd2, "key0 pp3 write denied");
    run("R7", MW, 1'b1, 1'b0, 1);
    chk("R7", {30'b0, result}, 32'd0, "key1 pp3 read allowed");
    put(PRI, 0, TP, 32'h4444_4001);
    run("R7", MW, 1'b1, 1'b1, 2);
    chk("R7", {30'b0, result}, 32'd2, "key1 pp1 write denied");
    put(PRI, 0, TP, 32'h4444_4002);
    run("R7", MW, 1'b1, 1'b1, 1);
    chk("R7", {30'b0, result}, 32'd0, "key1 pp2 write allowed");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule